// File: doc/BRIEF.md
# GF(2^233) Karatsuba Field Multiplier

This block is a bus-attached accelerator that multiplies two elements of the binary field GF(2^233). Elements are held in polynomial basis, so bit i of an element is the coefficient of x^i. A host CPU loads operand A and operand B as 32-bit words, writes a start register, waits for the `z_ready` flag, and then reads the 233-bit product back one word at a time.

Internally the operands are split into a low half and a high half of four words each. The three half-size products (low·low, high·high and (low⊕high)·(low⊕high)) are formed one 32×32 carry-less word product per cycle. The word multiplier itself uses one more Karatsuba split into 16-bit halves. Each word product is XORed straight into the right positions of a 465-bit accumulator, so no separate combine pass is needed. One more cycle folds the accumulator modulo x^233 + x^74 + 1 into the result register.

The bus is a plain register interface. A write is taken in the cycle it is presented, so there is no back-pressure on writes. Every read request is answered exactly two cycles later with `rd_valid`, and the host must be ready to take that data.

Top module: `gf233_kmul`

## Requirements
- R1: After a completed operation, the result equals A·B mod (x^233 + x^74 + 1). A word k (k = 0..7) is written at address k, B word k at address 8+k, and word k carries coefficients 32k..32k+31 in bits 0..31.
- R2: Bits 9..31 of operand word 7 (coefficients 233..255) are discarded when written, so the operation uses only coefficients 0..232.
- R3: Result word k is read at address k (k = 0..7), and bits 9..31 of result word 7 always read as zero.
- R4: A write of any data to address 16 while idle starts an operation. `z_ready` is low after the next edge and rises on the 50th clock edge counted from the accepting edge (48 word-product steps, plus one reduction step, plus the accepting edge).
- R5: A write to address 16 while an operation is running is ignored. It neither restarts nor lengthens the operation.
- R6: Operand writes while an operation is running are ignored. The stored operands stay unchanged for the current operation and for later ones.
- R7: A read request with `rd_en` high at clock edge t presents `rd_data` with `rd_valid` high after edge t+2. `rd_valid` is high only two cycles after a request.
- R8: Address 16 reads as status, with bit 0 equal to `z_ready` and all other bits zero. Unmapped read addresses (17..31) return zero.
- R9: After reset, `z_ready` is low and the operands and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken in the same cycle |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, two cycles after the request |
| rd_valid | output | 1 | Marks the cycle in which rd_data is valid |
| z_ready | output | 1 | Result available; cleared by an accepted start |

## Verification
The bench sweeps every pair drawn from a set of single-term operands x^i. The exponents sit on word edges, on half edges and at the reduction taps 74, 159 and 232, so every fold path of the reduction and every accumulator offset of the three Karatsuba terms is exercised. A wrong tap or a misplaced middle term shows up as a corrupted single bit. Dense and pseudo-random operands then check carry-less accumulation across many overlapping partial products.

Operands written with all ones in the top word check that bits above 232 are masked. A block that kept those bits would return a product with extra folded terms. A second start and an operand write are issued in the middle of an operation. A block that restarted would miss the 50-edge latency, and a block that accepted the write would return a different product, both now and on the next start without a reload.

// File: rtl/gf233_kmul_pkg.sv
package gf233_kmul_pkg;
  typedef enum logic [1:0] {
    KM_IDLE = 2'd0,
    KM_MUL  = 2'd1,
    KM_RED  = 2'd2
  } kmul_state_e;

  // Karatsuba term selected in a product step
  localparam logic [1:0] TERM_LO  = 2'd0;
  localparam logic [1:0] TERM_HI  = 2'd1;
  localparam logic [1:0] TERM_MID = 2'd2;
endpackage

// File: rtl/gfk_clmul.sv
// Schoolbook carry-less multiplier, N x N -> 2N-1 bits
module gfk_clmul #(
  parameter int N = 16
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-2:0] p
);
  localparam int PW = 2*N-1;

  always_comb begin
    p = '0;
    for (int i = 0; i < N; i++) begin
      if (b[i]) p = p ^ (PW'(a) << i);
    end
  end
endmodule

// File: rtl/gfk_word_mul.sv
// Word carry-less multiplier; USE_KARATSUBA picks one Karatsuba split or a flat product
module gfk_word_mul #(
  parameter int W = 32,
  parameter bit USE_KARATSUBA = 1'b1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  localparam int PW = 2*W-1;
  localparam int H  = W/2;

  generate
    if (USE_KARATSUBA) begin : g_kara
      logic [2*H-2:0] p_lo, p_hi, p_mx, p_mid;
      gfk_clmul #(.N(H)) u_lo (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_lo));
      gfk_clmul #(.N(H)) u_hi (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hi));
      gfk_clmul #(.N(H)) u_mx (.a(a[W-1:H] ^ a[H-1:0]),
                               .b(b[W-1:H] ^ b[H-1:0]), .p(p_mx));
      assign p_mid = p_mx ^ p_lo ^ p_hi;
      assign p = (PW'(p_hi) << W) ^ (PW'(p_mid) << H) ^ PW'(p_lo);
    end else begin : g_flat
      gfk_clmul #(.N(W)) u_full (.a(a), .b(b), .p(p));
    end
  endgenerate
endmodule

// File: rtl/gfk_operand_bank.sv
// Word-addressed operand storage; coefficients at or above M are dropped on write
module gfk_operand_bank #(
  parameter int W  = 32,
  parameter int NW = 8,
  parameter int M  = 233,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  output logic [NW*W-1:0] q
);
  function automatic logic [W-1:0] keep_mask(int k);
    for (int b = 0; b < W; b++) keep_mask[b] = ((k*W + b) < M);
  endfunction

  logic [W-1:0] words [NW];

  generate
    for (genvar k = 0; k < NW; k++) begin : g_word
      localparam logic [W-1:0] MASK = keep_mask(k);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            words[k] <= '0;
        else if (we && widx == IW'(k))         words[k] <= wdata & MASK;
      end
      assign q[k*W +: W] = words[k];
    end
  endgenerate
endmodule

// File: rtl/gfk_reduce.sv
// Two-pass fold modulo x^M + x^K + 1 (needs 2K-1 <= M)
module gfk_reduce #(
  parameter int M = 233,
  parameter int K = 74
) (
  input  logic [2*M-2:0] prod,
  output logic [M-1:0]   res
);
  localparam int TW = M + K - 1;

  logic [M-2:0]  hi1;
  logic [TW-1:0] t;
  logic [K-2:0]  hi2;

  always_comb begin
    hi1 = prod[2*M-2:M];
    t   = TW'(prod[M-1:0]) ^ TW'(hi1) ^ (TW'(hi1) << K);
    hi2 = t[TW-1:M];
    res = t[M-1:0] ^ M'(hi2) ^ (M'(hi2) << K);
  end
endmodule

// File: rtl/gf233_kmul.sv
module gf233_kmul
  import gf233_kmul_pkg::*;
#(
  parameter int W  = 32,
  parameter int M  = 233,
  parameter int K  = 74,
  parameter int AW = 5,
  parameter bit USE_KARATSUBA = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          z_ready
);
  // word count rounded up to an even number for the half split (power of two assumed)
  localparam int NW   = ((M + 2*W - 1) / (2*W)) * 2;
  localparam int HW   = NW / 2;
  localparam int IW   = $clog2(NW);
  localparam int HIW  = $clog2(HW);
  localparam int PRW  = 2*M - 1;
  localparam int HALF = HW * W;
  localparam int SHW  = $clog2(PRW);
  localparam int LAT  = 3*HW*HW + 2;
  localparam logic [AW-1:0] CMD_ADDR = AW'(2*NW);

  kmul_state_e state;
  logic [1:0]     ph;
  logic [HIW-1:0] ii, jj;
  logic [PRW-1:0] acc, ext, contrib;
  logic [NW*W-1:0] a_q, b_q, c_q;
  logic [W-1:0]   wa, wb;
  logic [2*W-2:0] wp;
  logic [SHW-1:0] sh;
  logic [M-1:0]   red;
  logic           busy, start_hit, a_we, b_we;

  assign busy      = (state != KM_IDLE);
  assign start_hit = wr_en && !busy && (wr_addr == CMD_ADDR);
  assign a_we      = wr_en && !busy && (wr_addr < AW'(NW));
  assign b_we      = wr_en && !busy && (wr_addr >= AW'(NW)) && (wr_addr < CMD_ADDR);

  gfk_operand_bank #(.W(W), .NW(NW), .M(M), .IW(IW)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .we(a_we), .widx(wr_addr[IW-1:0]),
    .wdata(wr_data), .q(a_q));
  gfk_operand_bank #(.W(W), .NW(NW), .M(M), .IW(IW)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .we(b_we), .widx(wr_addr[IW-1:0]),
    .wdata(wr_data), .q(b_q));

  // operand word select for the current Karatsuba term
  always_comb begin
    unique case (ph)
      TERM_LO: begin
        wa = a_q[32'(ii)*W +: W];
        wb = b_q[32'(jj)*W +: W];
      end
      TERM_HI: begin
        wa = a_q[(32'(ii)+HW)*W +: W];
        wb = b_q[(32'(jj)+HW)*W +: W];
      end
      default: begin
        wa = a_q[32'(ii)*W +: W] ^ a_q[(32'(ii)+HW)*W +: W];
        wb = b_q[32'(jj)*W +: W] ^ b_q[(32'(jj)+HW)*W +: W];
      end
    endcase
  end

  gfk_word_mul #(.W(W), .USE_KARATSUBA(USE_KARATSUBA)) u_wmul (
    .a(wa), .b(wb), .p(wp));

  // place the word product at its offsets in the full product
  always_comb begin
    sh  = SHW'((32'(ii) + 32'(jj)) * W);
    ext = PRW'(wp) << sh;
    unique case (ph)
      TERM_LO: contrib = ext ^ (ext << HALF);
      TERM_HI: contrib = (ext << HALF) ^ (ext << (2*HALF));
      default: contrib = ext << HALF;
    endcase
  end

  gfk_reduce #(.M(M), .K(K)) u_red (.prod(acc), .res(red));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= KM_IDLE;
      ph      <= '0;
      ii      <= '0;
      jj      <= '0;
      acc     <= '0;
      c_q     <= '0;
      z_ready <= 1'b0;
    end else begin
      unique case (state)
        KM_IDLE: if (start_hit) begin
          state   <= KM_MUL;
          ph      <= '0;
          ii      <= '0;
          jj      <= '0;
          acc     <= '0;
          z_ready <= 1'b0;
        end
        KM_MUL: begin
          acc <= acc ^ contrib;
          if (jj == HIW'(HW-1)) begin
            jj <= '0;
            if (ii == HIW'(HW-1)) begin
              ii <= '0;
              if (ph == TERM_MID) state <= KM_RED;
              else                ph    <= ph + 2'd1;
            end else begin
              ii <= ii + 1'b1;
            end
          end else begin
            jj <= jj + 1'b1;
          end
        end
        default: begin
          c_q     <= (NW*W)'(red);
          z_ready <= 1'b1;
          state   <= KM_IDLE;
        end
      endcase
    end
  end

  // two-stage read pipeline
  logic [W-1:0] rd_s1;
  logic         rv_s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s1    <= '0;
      rv_s1    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rv_s1 <= rd_en;
      if (rd_en) begin
        if (rd_addr < AW'(NW))       rd_s1 <= c_q[32'(rd_addr[IW-1:0])*W +: W];
        else if (rd_addr == CMD_ADDR) rd_s1 <= W'(z_ready);
        else                         rd_s1 <= '0;
      end
      rd_valid <= rv_s1;
      rd_data  <= rd_s1;
    end
  end
endmodule

// File: rtl/gf233_kmul_chk.sv
module gf233_kmul_chk #(
  parameter int W   = 32,
  parameter int NW  = 8,
  parameter int M   = 233,
  parameter int AW  = 5,
  parameter int LAT = 50
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic            rd_en,
  input logic [AW-1:0]   rd_addr,
  input logic            rd_valid,
  input logic [W-1:0]    rd_data,
  input logic            z_ready,
  input logic            busy,
  input logic [2*NW*W-1:0] ops
);
  localparam int TOPB = M - (NW-1)*W;
  localparam logic [AW-1:0] CMD_ADDR = AW'(2*NW);

  logic accept;
  logic [15:0] lat_q;
  assign accept = wr_en && !busy && (wr_addr == CMD_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lat_q <= '0;
    else if (accept)                lat_q <= 16'd1;
    else if (lat_q != 0 && !z_ready) lat_q <= lat_q + 16'd1;
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_ready) |-> lat_q == 16'(LAT));
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !z_ready);
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    z_ready |-> !busy);
  p_ops_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ops));
  p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ##2 rd_valid);
  p_rd_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en, 2));
  p_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_addr, 2) == AW'(NW-1)) |-> (rd_data >> TOPB) == '0);
  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_addr, 2) == CMD_ADDR) |-> rd_data[W-1:1] == '0);
endmodule

bind gf233_kmul gf233_kmul_chk #(
  .W(W), .NW(NW), .M(M), .AW(AW), .LAT(LAT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .z_ready(z_ready), .busy(busy), .ops({b_q, a_q})
);

// File: tb/gf233_kmul_tb_top.sv
module gf233_kmul_tb_top;
  localparam int EXP_LAT = 3*4*4 + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        z_ready;

  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  gf233_kmul dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .z_ready(z_ready));

  function automatic logic [232:0] ref_mul(logic [232:0] a, logic [232:0] b);
    logic [232:0] r = '0;
    logic top;
    for (int i = 232; i >= 0; i--) begin
      top = r[232];
      r = r << 1;
      if (top) begin r[74] = r[74] ^ 1'b1; r[0] = r[0] ^ 1'b1; end
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] addr, logic [31:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] addr, output logic [31:0] d, output bit v_ok);
    rd_en = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    v_ok = !rd_valid;
    @(negedge clk);
    v_ok = v_ok && rd_valid;
    d = rd_data;
  endtask

  task automatic load(logic [255:0] a, logic [255:0] b);
    for (int k = 0; k < 8; k++) wr(5'(k), a[32*k +: 32]);
    for (int k = 0; k < 8; k++) wr(5'(8+k), b[32*k +: 32]);
  endtask

  task automatic read_result(output logic [255:0] r);
    logic [31:0] d;
    bit v;
    for (int k = 0; k < 8; k++) begin
      rd(5'(k), d, v);
      r[32*k +: 32] = d;
      if (!v) check(1'b0, "R7 rd_valid timing", 256'(v), 256'(1));
    end
  endtask

  task automatic start_wait(output int cyc);
    wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    cyc = 1;
    check(z_ready == 1'b0, "R4 ready drop", 256'(z_ready), 256'(0));
    while (!z_ready && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_case(logic [255:0] a, logic [255:0] b, string req);
    int cyc;
    logic [255:0] got, exp;
    load(a, b);
    start_wait(cyc);
    check(cyc == EXP_LAT, "R4 latency", 256'(cyc), 256'(EXP_LAT));
    read_result(got);
    exp = 256'(ref_mul(a[232:0], b[232:0]));
    check(got == exp, req, got, exp);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 4; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      v[64*k +: 64] = rng;
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    int bl[13] = '{0, 1, 8, 31, 32, 73, 74, 127, 128, 159, 200, 224, 232};
    logic [31:0] d;
    logic [255:0] r, a0, b0, exp;
    bit v;
    int cyc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(z_ready == 1'b0, "R9 z_ready after reset", 256'(z_ready), 256'(0));
    read_result(r);
    check(r == '0, "R9 result after reset", r, '0);
    rd(5'd16, d, v);
    check(v && d == 32'h0, "R8 R9 status after reset", 256'(d), 256'(0));
    // operands zero: product of reset operands
    start_wait(cyc);
    read_result(r);
    check(r == '0, "R9 operands after reset", r, '0);

    // R1 single-term sweep over word, half and tap positions
    foreach (bl[x]) foreach (bl[y])
      run_case(256'(1) << bl[x], 256'(1) << bl[y], "R1 monomial product");

    // R1 dense and random patterns
    run_case({23'h0, {233{1'b1}}}, {23'h0, {233{1'b1}}}, "R1 all-ones product");
    for (int n = 0; n < 24; n++) begin
      a0 = rnd256(); b0 = rnd256();
      a0[255:233] = '0; b0[255:233] = '0;
      run_case(a0, b0, "R1 random product");
    end

    // R2 upper bits of the top word are discarded
    run_case('1, '1, "R2 top-word masking");
    a0 = rnd256(); b0 = rnd256();
    run_case(a0, b0, "R2 R3 unmasked random operands");
    rd(5'd7, d, v);
    check(v && (d >> 9) == 0, "R3 top result word high bits", 256'(d), 256'(d & 32'h1FF));

    // R8 status and unmapped read
    rd(5'd16, d, v);
    check(v && d == 32'h1, "R8 status ready", 256'(d), 256'(1));
    rd(5'd20, d, v);
    check(v && d == 32'h0, "R8 unmapped read", 256'(d), 256'(0));

    // R5 R6 start and operand writes during a running operation
    a0 = rnd256(); b0 = rnd256();
    a0[255:233] = '0; b0[255:233] = '0;
    load(a0, b0);
    exp = 256'(ref_mul(a0[232:0], b0[232:0]));
    wr_en = 1'b1; wr_addr = 5'd16; wr_data = '0;
    @(negedge clk);
    wr_en = 1'b0;
    cyc = 1;
    while (!z_ready && cyc < 1000) begin
      if (cyc == 10) begin wr_en = 1'b1; wr_addr = 5'd16; wr_data = '0; end
      else if (cyc == 12) begin wr_en = 1'b1; wr_addr = 5'd0; wr_data = ~a0[31:0]; end
      else if (cyc == 14) begin wr_en = 1'b1; wr_addr = 5'd9; wr_data = ~b0[63:32]; end
      else wr_en = 1'b0;
      @(negedge clk);
      cyc++;
    end
    wr_en = 1'b0;
    check(cyc == EXP_LAT, "R5 restart ignored latency", 256'(cyc), 256'(EXP_LAT));
    read_result(r);
    check(r == exp, "R5 R6 result with writes while busy", r, exp);
    start_wait(cyc);
    read_result(r);
    check(r == exp, "R6 operands kept after busy writes", r, exp);

    // R7 read pipeline timing
    rd_en = 1'b1; rd_addr = 5'd0;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid == 1'b0, "R7 not valid after one edge", 256'(rd_valid), 256'(0));
    @(negedge clk);
    check(rd_valid == 1'b1 && rd_data == exp[31:0], "R7 valid after two edges",
          256'(rd_data), 256'(exp[31:0]));
    @(negedge clk);
    check(rd_valid == 1'b0, "R7 single-cycle valid", 256'(rd_valid), 256'(0));

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule